// File: doc/BRIEF.md
# Atomic and Ordered Access Alignment Checker

This block sits in a load/store pipeline. For each atomic or ordered memory access it decides whether an alignment fault must be raised. It takes a base address, a short signed immediate, a size code, the access class, the direction and a translation-regime index. From these it forms the effective address, applies the alignment rule for that class and configuration, and returns one registered verdict per access.

Two plain control pins select the rule set:

- `cfg_relax` turns on the relaxed rule. Under it, a misaligned access of up to eight bytes is legal as long as it stays inside one 16-byte granule.
- `cfg_unal_ok` waives the check entirely for ordered accesses, but only while `cfg_relax` is set.

Both pins are sampled in the cycle an access is accepted.

The result travels with the faulting address, the direction and the regime index. A later exception stage can then report the fault without recomputing anything.

Input and output are a valid/ready pair with one register stage between them:

- An access is taken in any cycle where `in_valid` and `in_ready` are both high.
- Its verdict appears on the output one cycle later.
- `in_ready` is high whenever the output register is empty or being drained in the same cycle, so the stage sustains one access per cycle.
- While `out_valid` is high and `out_ready` is low, every output field holds its value and no new access is taken.

Top module: `align_guard`

## Requirements
- R1: An access with size code 0 (one byte) never reports a fault, in any class or configuration.
- R2: An access with size code 4 (16 bytes) faults exactly when the low four bits of its effective address are non-zero. This holds whatever `cfg_relax` and `cfg_unal_ok` are.
- R3: With `cfg_relax` low, an access with size code 1, 2 or 3 (2, 4 or 8 bytes) faults exactly when the low (size code) bits of its effective address are not all zero.
- R4: With `cfg_relax` high, an atomic access (`in_ordered` = 0) with size code 1 to 3 faults exactly when (effective address mod 16) plus its byte count exceeds 16.
- R5: With `cfg_relax` high and `cfg_unal_ok` high, an ordered access (`in_ordered` = 1) with size code 1 to 3 never faults.
- R6: With `cfg_relax` high and `cfg_unal_ok` low, an ordered access with size code 1 to 3 uses the same 16-byte crossing test as R4.
- R7: The effective address is `in_base` plus `in_ofs` sign-extended from 9 bits, modulo 2^64, for ordered accesses. For atomic accesses it is `in_base` alone, and `in_ofs` has no effect. `out_addr` carries this effective address.
- R8: `out_store` is 1 for every atomic access and equals `in_store` (1 = store) for ordered accesses. `out_regime` equals the `in_regime` of the same access.
- R9: Size codes 5, 6 and 7 are not legal and always report a fault.
- R10: The stage behaves as follows:
  - An access accepted at one clock edge shows its result with `out_valid` high after that edge.
  - `in_ready` equals `!out_valid || out_ready`.
  - While `out_valid` is high and `out_ready` is low, all outputs stay stable.
- R11: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Access request valid |
| in_ready | output | 1 | Stage can take a request |
| in_base | input | 64 | Base address |
| in_ofs | input | 9 | Signed immediate offset (ordered class only) |
| in_size | input | 3 | Size code: 0..4 = 1, 2, 4, 8, 16 bytes |
| in_ordered | input | 1 | Access class: 1 = ordered, 0 = atomic |
| in_store | input | 1 | Direction: 1 = store, 0 = load |
| in_regime | input | 2 | Translation-regime index |
| cfg_relax | input | 1 | Relaxed 16-byte granule rule enable |
| cfg_unal_ok | input | 1 | Waive the check for ordered accesses when relaxed |
| out_valid | output | 1 | Verdict valid |
| out_ready | input | 1 | Consumer takes the verdict |
| out_fault | output | 1 | Alignment fault raised |
| out_addr | output | 64 | Effective address |
| out_store | output | 1 | Reported direction (1 = store) |
| out_regime | output | 2 | Reported regime index |

## Verification
The main sweep covers the following space:

- every size code, all sixteen low address phases and two upper base patterns, one of which wraps when the offset is added;
- seven offsets, including the most negative and most positive values;
- both classes and all four settings of the two control pins.

The phase sweep separates the natural-alignment rule from the granule-crossing rule. The two rules agree at some phases (for example 8 bytes at phase 8) and disagree at others (for example 4 bytes at phase 2). Running the same addresses with the ordered waiver on and off shows that the waiver reaches only the ordered class, and that it does not relax 16-byte or illegal sizes. A stall sequence holds `out_ready` low while a second access waits, which shows that the result is held and the second access is delayed rather than lost.

// File: rtl/align_guard_pkg.sv
package align_guard_pkg;

  typedef enum logic {
    ACC_ATOMIC  = 1'b0,
    ACC_ORDERED = 1'b1
  } acc_cls_e;

  // log2 of the granule an access may not straddle under the relaxed rule
  localparam int unsigned GRAN_LG = 4;

endpackage

// File: rtl/ag_addr_gen.sv
module ag_addr_gen #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned OFS_W  = 9
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              use_ofs,
  output logic [ADDR_W-1:0] ea
);
  logic [ADDR_W-1:0] ofs_ext;

  generate
    if (OFS_W < ADDR_W) begin : g_sext
      assign ofs_ext = {{(ADDR_W-OFS_W){ofs[OFS_W-1]}}, ofs};
    end else begin : g_trunc
      assign ofs_ext = ofs[ADDR_W-1:0];
    end
  endgenerate

  // Atomic accesses ignore the immediate entirely.
  assign ea = base + (use_ofs ? ofs_ext : '0);
endmodule

// File: rtl/ag_rule_eval.sv
module ag_rule_eval #(
  parameter int unsigned SZ_W    = 3,
  parameter int unsigned GRAN_LG = align_guard_pkg::GRAN_LG
) (
  input  logic [GRAN_LG-1:0] ea_lo,
  input  logic [SZ_W-1:0]    sz,
  input  logic               ordered,
  input  logic               relax,
  input  logic               unal_ok,
  output logic               fault
);
  localparam int unsigned GRAN = 1 << GRAN_LG;

  logic [GRAN_LG:0]   nbytes;
  logic [GRAN_LG:0]   span_end;
  logic [GRAN_LG:0]   amask;
  logic               misaligned;
  logic               crosses;

  always_comb begin
    nbytes     = (GRAN_LG+1)'(1) << sz;
    amask      = nbytes - (GRAN_LG+1)'(1);
    misaligned = |(ea_lo & amask[GRAN_LG-1:0]);
    span_end   = {1'b0, ea_lo} + nbytes;
    crosses    = span_end > (GRAN_LG+1)'(GRAN);
  end

  // Rule priority: illegal size, byte, full granule, strict, ordered waiver, crossing.
  always_comb begin
    if (sz > SZ_W'(GRAN_LG))            fault = 1'b1;
    else if (sz == '0)                  fault = 1'b0;
    else if (sz == SZ_W'(GRAN_LG))      fault = misaligned;
    else if (!relax)                    fault = misaligned;
    else if (ordered && unal_ok)        fault = 1'b0;
    else                                fault = crosses;
  end
endmodule

// File: rtl/ag_out_stage.sv
module ag_out_stage #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SZ_W   = 3,
  parameter int unsigned RG_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              d_fault,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic              d_store,
  input  logic [RG_W-1:0]   d_regime,
  input  logic [SZ_W-1:0]   d_sz,
  input  logic              d_ordered,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_fault,
  output logic [ADDR_W-1:0] m_addr,
  output logic              m_store,
  output logic [RG_W-1:0]   m_regime
);
  logic [SZ_W-1:0] sz_q;
  logic            ord_q;

  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid  <= 1'b0;
      m_fault  <= 1'b0;
      m_addr   <= '0;
      m_store  <= 1'b0;
      m_regime <= '0;
      sz_q     <= '0;
      ord_q    <= 1'b0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) begin
        m_fault  <= d_fault;
        m_addr   <= d_addr;
        m_store  <= d_store;
        m_regime <= d_regime;
        sz_q     <= d_sz;
        ord_q    <= d_ordered;
      end
    end
  end

  // R1: a single byte never faults
  p_byte_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && sz_q == '0) |-> !m_fault);
  // R2: a passing 16-byte access sits on a granule boundary
  p_quad_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && sz_q == SZ_W'(align_guard_pkg::GRAN_LG) && !m_fault) |-> (m_addr[3:0] == 4'd0));
  // R8: atomic class is reported as a store
  p_atomic_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !ord_q) |-> m_store);
  // R9: illegal size codes always fault
  p_bad_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && sz_q > SZ_W'(align_guard_pkg::GRAN_LG)) |-> m_fault);
  // R10: a stalled result is held
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_fault)
                               && $stable(m_store) && $stable(m_regime)));
  // R10: empty stage always accepts
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid |-> s_ready);
endmodule

// File: rtl/align_guard.sv
module align_guard #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned OFS_W  = 9,
  parameter int unsigned SZ_W   = 3,
  parameter int unsigned RG_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [OFS_W-1:0]  in_ofs,
  input  logic [SZ_W-1:0]   in_size,
  input  logic              in_ordered,
  input  logic              in_store,
  input  logic [RG_W-1:0]   in_regime,
  input  logic              cfg_relax,
  input  logic              cfg_unal_ok,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_fault,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_store,
  output logic [RG_W-1:0]   out_regime
);
  import align_guard_pkg::*;

  acc_cls_e          cls;
  logic [ADDR_W-1:0] ea;
  logic              fault_d;
  logic              store_d;

  assign cls     = acc_cls_e'(in_ordered);
  assign store_d = (cls == ACC_ATOMIC) ? 1'b1 : in_store;

  ag_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
    .base    (in_base),
    .ofs     (in_ofs),
    .use_ofs (cls == ACC_ORDERED),
    .ea      (ea)
  );

  ag_rule_eval #(.SZ_W(SZ_W), .GRAN_LG(GRAN_LG)) u_rule (
    .ea_lo   (ea[GRAN_LG-1:0]),
    .sz      (in_size),
    .ordered (cls == ACC_ORDERED),
    .relax   (cfg_relax),
    .unal_ok (cfg_unal_ok),
    .fault   (fault_d)
  );

  ag_out_stage #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .RG_W(RG_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (in_valid),
    .s_ready   (in_ready),
    .d_fault   (fault_d),
    .d_addr    (ea),
    .d_store   (store_d),
    .d_regime  (in_regime),
    .d_sz      (in_size),
    .d_ordered (in_ordered),
    .m_valid   (out_valid),
    .m_ready   (out_ready),
    .m_fault   (out_fault),
    .m_addr    (out_addr),
    .m_store   (out_store),
    .m_regime  (out_regime)
  );

  // R11: nothing valid right after reset
  p_reset_empty_r11: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/sim_align_guard.sv
module sim_align_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_base = '0;
  logic [8:0]  in_ofs = '0;
  logic [2:0]  in_size = '0;
  logic        in_ordered = 1'b0;
  logic        in_store = 1'b0;
  logic [1:0]  in_regime = '0;
  logic        cfg_relax = 1'b0;
  logic        cfg_unal_ok = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_fault;
  logic [63:0] out_addr;
  logic        out_store;
  logic [1:0]  out_regime;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  align_guard u0 (.*);

  // expected result of the last driven access
  logic        e_fault;
  logic [63:0] e_addr;
  logic        e_store;
  logic [1:0]  e_regime;
  string       e_tag;

  task automatic predict(input logic [63:0] b, input logic [8:0] o, input logic [2:0] s,
                         input logic ord, input logic st, input logic [1:0] rg,
                         input logic rlx, input logic una);
    longint unsigned ea;
    int ph, nb;
    ea = ord ? (b + {{55{o[8]}}, o}) : b;
    ph = int'(ea % 16);
    nb = 1 << s;
    e_addr = ea;
    e_store = ord ? st : 1'b1;
    e_regime = rg;
    if (s > 4) begin e_fault = 1'b1; e_tag = "R9"; end
    else if (s == 0) begin e_fault = 1'b0; e_tag = "R1"; end
    else if (s == 4) begin e_fault = (ph != 0); e_tag = "R2"; end
    else if (!rlx) begin e_fault = (ph % nb) != 0; e_tag = "R3"; end
    else if (!ord) begin e_fault = (ph + nb) > 16; e_tag = "R4"; end
    else if (una) begin e_fault = 1'b0; e_tag = "R5"; end
    else begin e_fault = (ph + nb) > 16; e_tag = "R6"; end
  endtask

  task automatic check_out(input string tag);
    n_checks++;
    if (out_valid !== 1'b1 || out_fault !== e_fault) begin
      n_fail++;
      $display("FAIL %s fault: valid=%0b fault=%0b expected valid=1 fault=%0b", tag, out_valid, out_fault, e_fault);
    end
    n_checks++;
    if (out_addr !== e_addr) begin
      n_fail++;
      $display("FAIL R7 addr: got %h expected %h", out_addr, e_addr);
    end
    n_checks++;
    if (out_store !== e_store || out_regime !== e_regime) begin
      n_fail++;
      $display("FAIL R8 store/regime: got %0b/%0d expected %0b/%0d", out_store, out_regime, e_store, e_regime);
    end
  endtask

  // called at a negedge; result is checked at the following negedge
  task automatic send(input logic [63:0] b, input logic [8:0] o, input logic [2:0] s,
                      input logic ord, input logic st, input logic [1:0] rg,
                      input logic rlx, input logic una);
    in_base = b; in_ofs = o; in_size = s; in_ordered = ord; in_store = st;
    in_regime = rg; cfg_relax = rlx; cfg_unal_ok = una; in_valid = 1'b1;
    predict(b, o, s, ord, st, rg, rlx, una);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(e_tag);
  endtask

  task automatic chk1(input string tag, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [8:0]  ofs_tab [7];
    logic [63:0] hi_tab [2];
    logic [63:0] a_addr;
    ofs_tab = '{9'h000, 9'h001, 9'h1FF, 9'h00F, 9'h100, 9'h0FF, 9'h007};
    hi_tab  = '{64'h0000_0000_1234_5670, 64'hFFFF_FFFF_FFFF_FFF0};

    repeat (3) @(negedge clk);
    chk1("R11 out_valid in reset", out_valid, 1'b0);
    chk1("R11 in_ready in reset", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk1("R11 out_valid after reset", out_valid, 1'b0);

    // R1..R9: sweep of sizes, phases, offsets, class and configuration
    for (int h = 0; h < 2; h++)
      for (int s = 0; s < 8; s++)
        for (int p = 0; p < 16; p++)
          for (int k = 0; k < 7; k++)
            for (int c = 0; c < 8; c++)
              send(hi_tab[h] | 64'(p), ofs_tab[k], 3'(s), c[0], c[1] ^ p[0],
                   2'(p + k), c[1], c[2]);

    // R7: atomic ignores offset even when it would change alignment
    send(64'h100, 9'h001, 3'd2, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0);
    chk1("R7 atomic ignores offset", out_fault, 1'b0);

    // R10: back-pressure
    @(negedge clk);
    send(64'h20, 9'h000, 3'd3, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0);
    a_addr = out_addr;
    out_ready = 1'b0;
    in_base = 64'h33; in_size = 3'd1; in_ordered = 1'b1; in_ofs = 9'h000;
    in_store = 1'b1; in_regime = 2'd2; cfg_relax = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk1("R10 in_ready low while stalled", in_ready, 1'b0);
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b1 || out_addr !== a_addr || out_fault !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 hold: got v=%0b addr=%h expected v=1 addr=%h", out_valid, out_addr, a_addr);
    end
    out_ready = 1'b1;
    predict(64'h33, 9'h000, 3'd1, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R10 waiting access delivered");
    @(negedge clk);
    chk1("R10 drained", out_valid, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule